// File: doc/BRIEF.md
# Watchdog Timer with Keyed Software Disable

This block watches a running system and issues a one-cycle reset pulse if software fails to restart its count within a selectable window. A 15-bit counter advances on every clock while the watchdog runs. When the count reaches the terminal value of the selected window, a reset pulse leaves the block and counting starts over. Software avoids the reset by strobing a clear request often enough.

An 8-bit control register sits on a simple register bus made of a write enable, write data and read data. It holds a 3-bit window select that picks one of eight power-of-two periods from 256 to 32768 cycles. It also holds a 4-bit software key and one spare control bit. The spare bit is only passed out to the idle-clock logic.

Turning the watchdog off takes two conditions together. The static configuration-enable input must be low, and the software key must hold one exact pattern. Any other key value keeps the watchdog running, so a stray write that corrupts the key cannot silence it.

Top module: `wdt_keyed`

## Requirements
- R1: The window select in control bits [6:4] sets the period to 2^(8+sel) cycles, where sel is the unsigned value of those bits. Measured from the edge that restarts the count, the reset pulse appears on the 2^(8+sel)-th following clock edge.
- R2: The watchdog is off only when cfg_en_i is low and control bits [3:0] equal 4'b1010. Every other combination runs it. While off, the counter is held at zero and no pulse is produced. After it turns on, the first pulse comes a full period later.
- R3: wdt_rst_o is high for exactly one clock cycle per timeout.
- R4: The counter restarts from zero on the edge that raises the pulse, so pulses repeat every period while no clear arrives.
- R5: A clear request restarts the count from zero. A clear in the same cycle as the terminal count wins, and no pulse follows. While the watchdog is off, clears have no effect.
- R6: After reset the control register reads 8'h7A (bit 7 = 0, select = 3'b111, key = 4'b1010) and wdt_rst_o is low.
- R7: A write that changes the select does not clear the counter. The new period is used from the next cycle's compare. If the count already lies past the new terminal value, the pulse appears one cycle after the write takes effect.
- R8: Control bit 7 drives idle_clk_o directly and has no effect on counting or timing.
- R9: rd_data_o always shows the current control register contents, including the value of the last write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the counter advances once per rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_en_i | input | 1 | Static configuration enable; high forces the watchdog on |
| clr_i | input | 1 | Clear request strobe; restarts the count |
| wr_en_i | input | 1 | Write strobe for the control register |
| wr_data_i | input | 8 | Control register write data |
| rd_data_o | output | 8 | Control register read data |
| idle_clk_o | output | 1 | Copy of control bit 7 for the idle-clock logic |
| wdt_rst_o | output | 1 | One-cycle reset pulse on timeout |

## Verification
The hardest case to reach from the ports is a clear that lands in the very cycle the counter sits at its terminal value. The bench arms the counter with a write and a clear issued together, which gives a known zero point. It then counts exactly 255 cycles at the 256-cycle select and strobes the clear there. The pulse must stay low, and the next pulse must come one full period later. A shrinking select applied while the count is already past the new limit is reached the same way: the count runs on the longest window for about a thousand cycles before the write.

// File: rtl/wdt_keyed_pkg.sv
`timescale 1ns/1ps
// Package: shared constants and the run-state type of the keyed watchdog.
// Assumes: every module of the block imports it; the defaults here are the
// values used when the top is elaborated without overrides.
package wdt_keyed_pkg;

    // Default geometry of the control register and counter
    localparam int unsigned WDT_SEL_W    = 3;
    localparam int unsigned WDT_KEY_W    = 4;
    localparam int unsigned WDT_CNT_W    = 15;
    localparam int unsigned WDT_BASE_EXP = 8;

    // Key pattern that, together with a low config enable, stops the watchdog
    localparam logic [WDT_KEY_W-1:0] WDT_OFF_KEY = 4'b1010;

    // Reset contents of the control register fields
    localparam logic [WDT_SEL_W-1:0] WDT_RST_SEL  = 3'b111;
    localparam logic                 WDT_RST_IDLE = 1'b0;

    // Whether the watchdog counts or is held
    typedef enum logic {
        WDT_HELD = 1'b0,
        WDT_RUN  = 1'b1
    } wdt_run_e;

endpackage

// File: rtl/wdt_ctrl_reg.sv
`timescale 1ns/1ps
// Module: control register of the watchdog.
// Holds an idle-clock bit, a window select and a software key, packed
// MSB to LSB as {idle, sel, key}. Assumes a single-cycle write strobe and
// that read data is always valid (no read strobe).
module wdt_ctrl_reg #(
    parameter int unsigned        SEL_W    = 3,
    parameter int unsigned        KEY_W    = 4,
    parameter logic [SEL_W-1:0]   RST_SEL  = '1,
    parameter logic [KEY_W-1:0]   RST_KEY  = '0,
    parameter logic               RST_IDLE = 1'b0,
    localparam int unsigned       REG_W    = 1 + SEL_W + KEY_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en_i,
    input  logic [REG_W-1:0] wr_data_i,
    output logic [REG_W-1:0] rd_data_o,
    output logic [SEL_W-1:0] sel_o,
    output logic [KEY_W-1:0] key_o,
    output logic             idle_o
);

    localparam int unsigned KEY_LO = 0;
    localparam int unsigned SEL_LO = KEY_W;
    localparam int unsigned IDLE_B = KEY_W + SEL_W;

    logic [REG_W-1:0] ctrl_q;

    // Load the whole register on a write; return to the reset pattern on reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= {RST_IDLE, RST_SEL, RST_KEY};
        end else if (wr_en_i) begin
            ctrl_q <= wr_data_i;
        end
    end

    // Split the register into its fields
    always_comb begin
        key_o     = ctrl_q[KEY_LO +: KEY_W];
        sel_o     = ctrl_q[SEL_LO +: SEL_W];
        idle_o    = ctrl_q[IDLE_B];
        rd_data_o = ctrl_q;
    end

endmodule

// File: rtl/wdt_enable_gate.sv
`timescale 1ns/1ps
// Module: enable rule of the watchdog.
// The watchdog is held only when the static config enable is low and the
// software key matches the off pattern exactly. Any other key value runs it.
// Assumes cfg_en_i is quasi-static; no synchronisation is done here.
module wdt_enable_gate
    import wdt_keyed_pkg::*;
#(
    parameter int unsigned      KEY_W   = 4,
    parameter logic [KEY_W-1:0] OFF_KEY = '0
) (
    input  logic             cfg_en_i,
    input  logic [KEY_W-1:0] key_i,
    output wdt_run_e         run_o
);

    logic key_is_off;

    // Decide between counting and holding from the two enable sources
    always_comb begin
        key_is_off = (key_i == OFF_KEY);
        run_o      = (cfg_en_i || !key_is_off) ? WDT_RUN : WDT_HELD;
    end

endmodule

// File: rtl/wdt_period_dec.sv
`timescale 1ns/1ps
// Module: window decoder.
// Maps the select code to the terminal count (period minus one) of a
// power-of-two window: period = 2^(BASE_EXP + sel). Assumes
// BASE_EXP + 2^SEL_W - 1 <= CNT_W so the largest window fits the counter.
module wdt_period_dec #(
    parameter int unsigned SEL_W    = 3,
    parameter int unsigned CNT_W    = 15,
    parameter int unsigned BASE_EXP = 8,
    localparam int unsigned NUM_SEL = 1 << SEL_W
) (
    input  logic [SEL_W-1:0] sel_i,
    output logic [CNT_W-1:0] term_o
);

    logic [CNT_W-1:0] term_lut [NUM_SEL];

    // One terminal count per select code, computed at elaboration
    for (genvar g = 0; g < NUM_SEL; g++) begin : g_term
        assign term_lut[g] = CNT_W'((64'd1 << (BASE_EXP + g)) - 64'd1);
    end

    // Pick the terminal count of the current select
    always_comb begin
        term_o = term_lut[sel_i];
    end

endmodule

// File: rtl/wdt_counter.sv
`timescale 1ns/1ps
// Module: timeout counter and pulse generator.
// Counts while running, restarts on clear, on timeout and while held.
// A timeout is a count at or past the terminal value; a clear in the same
// cycle suppresses it. The pulse is registered and one cycle wide.
// Assumes term_i may change at any cycle (select writes).
module wdt_counter
    import wdt_keyed_pkg::*;
#(
    parameter int unsigned CNT_W = 15
) (
    input  logic             clk,
    input  logic             rst_n,
    input  wdt_run_e         run_i,
    input  logic             clr_i,
    input  logic [CNT_W-1:0] term_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             expire_o
);

    logic [CNT_W-1:0] cnt_q;
    logic             expire_q;
    logic             hit;
    logic             restart;

    // Timeout and restart conditions for this cycle
    always_comb begin
        hit     = (run_i == WDT_RUN) && !clr_i && (cnt_q >= term_i);
        restart = (run_i == WDT_HELD) || clr_i || hit;
    end

    // Advance or restart the count and register the timeout pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q    <= '0;
            expire_q <= 1'b0;
        end else begin
            expire_q <= hit;
            if (restart) begin
                cnt_q <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign cnt_o    = cnt_q;
    assign expire_o = expire_q;

endmodule

// File: rtl/wdt_keyed.sv
`timescale 1ns/1ps
// Module: keyed-disable watchdog timer (top).
// Ties the control register, enable rule, window decoder and counter
// together. Assumes a single clock domain and a synchronous active-low reset.
module wdt_keyed
    import wdt_keyed_pkg::*;
#(
    parameter int unsigned SEL_W    = WDT_SEL_W,
    parameter int unsigned KEY_W    = WDT_KEY_W,
    parameter int unsigned CNT_W    = WDT_CNT_W,
    parameter int unsigned BASE_EXP = WDT_BASE_EXP,
    localparam int unsigned REG_W   = 1 + SEL_W + KEY_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_en_i,
    input  logic             clr_i,
    input  logic             wr_en_i,
    input  logic [REG_W-1:0] wr_data_i,
    output logic [REG_W-1:0] rd_data_o,
    output logic             idle_clk_o,
    output logic             wdt_rst_o
);

    logic [SEL_W-1:0] sel;
    logic [KEY_W-1:0] key;
    logic [CNT_W-1:0] term;
    logic [CNT_W-1:0] cnt;
    wdt_run_e         run;

    // Software-visible control register
    wdt_ctrl_reg #(
        .SEL_W    (SEL_W),
        .KEY_W    (KEY_W),
        .RST_SEL  (SEL_W'(WDT_RST_SEL)),
        .RST_KEY  (KEY_W'(WDT_OFF_KEY)),
        .RST_IDLE (WDT_RST_IDLE)
    ) u_reg (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en_i),
        .wr_data_i (wr_data_i),
        .rd_data_o (rd_data_o),
        .sel_o     (sel),
        .key_o     (key),
        .idle_o    (idle_clk_o)
    );

    // Run/hold decision from config enable and key
    wdt_enable_gate #(
        .KEY_W   (KEY_W),
        .OFF_KEY (KEY_W'(WDT_OFF_KEY))
    ) u_gate (
        .cfg_en_i (cfg_en_i),
        .key_i    (key),
        .run_o    (run)
    );

    // Terminal count of the selected window
    wdt_period_dec #(
        .SEL_W    (SEL_W),
        .CNT_W    (CNT_W),
        .BASE_EXP (BASE_EXP)
    ) u_dec (
        .sel_i  (sel),
        .term_o (term)
    );

    // Counter and reset pulse
    wdt_counter #(
        .CNT_W (CNT_W)
    ) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_i    (run),
        .clr_i    (clr_i),
        .term_i   (term),
        .cnt_o    (cnt),
        .expire_o (wdt_rst_o)
    );

endmodule

// File: rtl/wdt_keyed_chk.sv
`timescale 1ns/1ps
// Module: property checker for the keyed watchdog, bound into the top.
// Observes ports and the internal count, key and terminal value.
module wdt_keyed_chk #(
    parameter int unsigned KEY_W = 4,
    parameter int unsigned CNT_W = 15,
    parameter int unsigned REG_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_en_i,
    input logic             clr_i,
    input logic [KEY_W-1:0] key,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] term,
    input logic [REG_W-1:0] rd_data_o,
    input logic             wdt_rst_o
);

    logic held;
    assign held = !cfg_en_i && (key == 4'b1010);

    // R3
    pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_rst_o |=> !wdt_rst_o);

    // R5
    clear_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (!wdt_rst_o && cnt == '0));

    // R2
    held_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        held |=> (!wdt_rst_o && cnt == '0));

    // R4
    restart_after_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_rst_o |-> cnt == '0);

    // R1
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!held && !clr_i && cnt < term) |=> (cnt == $past(cnt) + 1'b1));

    // R6
    reset_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (rd_data_o == 8'h7A && !wdt_rst_o));

endmodule

bind wdt_keyed wdt_keyed_chk #(
    .KEY_W (KEY_W),
    .CNT_W (CNT_W),
    .REG_W (REG_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_en_i  (cfg_en_i),
    .clr_i     (clr_i),
    .key       (key),
    .cnt       (cnt),
    .term      (term),
    .rd_data_o (rd_data_o),
    .wdt_rst_o (wdt_rst_o)
);

// File: tb/wdt_keyed_test.sv
`timescale 1ns/1ps
// Directed bench for the keyed watchdog; one task per scenario.
module wdt_keyed_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_en_i = 1'b0;
    logic       clr_i = 1'b0;
    logic       wr_en_i = 1'b0;
    logic [7:0] wr_data_i = 8'h00;
    logic [7:0] rd_data_o;
    logic       idle_clk_o;
    logic       wdt_rst_o;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    wdt_keyed uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_en_i   (cfg_en_i),
        .clr_i      (clr_i),
        .wr_en_i    (wr_en_i),
        .wr_data_i  (wr_data_i),
        .rd_data_o  (rd_data_o),
        .idle_clk_o (idle_clk_o),
        .wdt_rst_o  (wdt_rst_o)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
        end
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Write the register and strobe a clear in the same cycle
    task automatic arm(input logic [7:0] d);
        wr_en_i = 1'b1; wr_data_i = d; clr_i = 1'b1;
        @(negedge clk);
        wr_en_i = 1'b0; clr_i = 1'b0;
    endtask

    task automatic wr(input logic [7:0] d);
        wr_en_i = 1'b1; wr_data_i = d;
        @(negedge clk);
        wr_en_i = 1'b0;
    endtask

    // Count negedges until the pulse is seen; 0 when none within the cap
    task automatic measure(input int cap, output int n);
        n = 0;
        for (int i = 1; i <= cap; i++) begin
            @(negedge clk);
            if (wdt_rst_o) begin n = i; return; end
        end
    endtask

    task automatic t_reset();
        chk(rd_data_o == 8'h7A, "R6 reset value", rd_data_o, 8'h7A);
        chk(wdt_rst_o == 1'b0, "R6 pulse low after reset", wdt_rst_o, 0);
        chk(idle_clk_o == 1'b0, "R8 idle bit after reset", idle_clk_o, 0);
    endtask

    task automatic t_disabled();
        int pulses = 0;
        cfg_en_i = 1'b0;
        wr(8'h0A);
        chk(rd_data_o == 8'h0A, "R9 readback", rd_data_o, 8'h0A);
        for (int i = 0; i < 600; i++) begin
            clr_i = (i % 50 == 0);
            @(negedge clk);
            if (wdt_rst_o) pulses++;
        end
        clr_i = 1'b0;
        chk(pulses == 0, "R2/R5 held watchdog silent, clears ignored", pulses, 0);
    endtask

    task automatic t_cfg_enable();
        int n;
        cfg_en_i = 1'b1;
        measure(1000, n);
        chk(n == 256, "R2 first pulse a full period after config enable", n, 256);
        @(negedge clk);
        chk(wdt_rst_o == 1'b0, "R3 pulse one cycle wide", wdt_rst_o, 0);
        measure(1000, n);
        chk(n == 255, "R4 periodic restart", n, 255);
    endtask

    task automatic t_key_enable();
        int n;
        cfg_en_i = 1'b0;
        tick(5);
        arm(8'h0B);
        measure(1000, n);
        chk(n == 256, "R2 non-off key runs with config low", n, 256);
    endtask

    task automatic t_periods();
        int n;
        cfg_en_i = 1'b1;
        for (int s = 0; s < 8; s++) begin
            arm({1'b0, 3'(s), 4'b0101});
            chk(rd_data_o == {1'b0, 3'(s), 4'b0101}, "R9 readback of select", rd_data_o, {1'b0, 3'(s), 4'b0101});
            measure(40000, n);
            chk(n == (1 << (8 + s)), "R1 period for select", n, 1 << (8 + s));
        end
    endtask

    task automatic t_clear_holds();
        int pulses = 0;
        arm(8'h05);
        for (int k = 0; k < 10; k++) begin
            for (int i = 0; i < 200; i++) begin
                @(negedge clk);
                if (wdt_rst_o) pulses++;
            end
            clr_i = 1'b1;
            @(negedge clk);
            clr_i = 1'b0;
            if (wdt_rst_o) pulses++;
        end
        chk(pulses == 0, "R5 regular clears prevent timeout", pulses, 0);
    endtask

    task automatic t_clear_collision();
        int n;
        arm(8'h05);
        tick(255);
        chk(wdt_rst_o == 1'b0, "R5 no pulse before terminal", wdt_rst_o, 0);
        clr_i = 1'b1;
        @(negedge clk);
        clr_i = 1'b0;
        chk(wdt_rst_o == 1'b0, "R5 clear at terminal count wins", wdt_rst_o, 0);
        measure(1000, n);
        chk(n == 256, "R5 count restarted by colliding clear", n, 256);
    endtask

    task automatic t_sel_change();
        int n;
        arm(8'h75);
        tick(999);
        wr(8'h05);
        chk(wdt_rst_o == 1'b0, "R7 no pulse on write edge", wdt_rst_o, 0);
        @(negedge clk);
        chk(wdt_rst_o == 1'b1, "R7 count past new limit times out next cycle", wdt_rst_o, 1);
        arm(8'h75);
        tick(99);
        wr(8'h05);
        measure(1000, n);
        chk(n == 156, "R7 select write keeps the count", n, 156);
    endtask

    task automatic t_idle_bit();
        int n;
        arm(8'h85);
        chk(idle_clk_o == 1'b1, "R8 idle bit driven out", idle_clk_o, 1);
        chk(rd_data_o == 8'h85, "R9 readback with bit 7", rd_data_o, 8'h85);
        measure(1000, n);
        chk(n == 256, "R8 idle bit leaves timing unchanged", n, 256);
        wr(8'h05);
        chk(idle_clk_o == 1'b0, "R8 idle bit cleared", idle_clk_o, 0);
    endtask

    initial begin
        fork
            begin
                tick(4);
                rst_n = 1'b1;
                @(negedge clk);
                t_reset();
                t_disabled();
                t_cfg_enable();
                t_key_enable();
                t_periods();
                t_clear_holds();
                t_clear_collision();
                t_sel_change();
                t_idle_bit();
            end
            begin
                tick(190000);
                checks++;
                fails++;
                $display("FAIL watchdog: run did not finish, actual timeout expected completion");
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule